// File: doc/BRIEF.md
# Paged Address Translator with Access Guard

This block maps a logical address to a physical one through a small page table kept in on-chip registers. The same lookup checks the access against the permissions stored with the entry. A requester presents a logical address, an access kind (read, write or instruction fetch) and a one-cycle request strobe. One clock later the block returns a done pulse. With it comes either the translated physical address or a fault flag and a two-bit code that says why the access was refused.

A configuration port writes one table entry per cycle. An entry holds a frame number, a present bit and three permission bits (read, write, execute). The physical address is the entry's frame number placed above the untouched page offset. The default build has eight pages of 4 KiB and 8-bit frame numbers. A common setup marks only the first six pages present, so any access to pages 6 or 7 is refused. Trap handling is left to the logic that consumes the fault.

Top module: `page_guard`

## Requirements
- R1: Reset marks every table entry not present and drives physAddr, done, fault and faultCause to zero. A request after reset, to any page, faults with cause 01.
- R2: For every cycle in which reqValid is high at a rising clock edge, done is high for exactly the following cycle. It is low after a cycle without a request.
- R3: A permitted access returns physAddr = {frame of the selected entry, reqAddr[OFFSET_BITS-1:0]}, with fault low and faultCause 00. The page index is reqAddr[OFFSET_BITS+PAGE_BITS-1:OFFSET_BITS].
- R4: An access to an entry whose present bit is clear faults with cause 01, whatever its kind and permission bits.
- R5: A write (reqKind 01) to a present entry whose write bit is clear faults with cause 10.
- R6: A read to a present entry whose read bit is clear, or a fetch to one whose execute bit is clear, faults with cause 11.
- R7: When a fault is reported, physAddr is zero and done still pulses once. fault is high exactly when faultCause is nonzero.
- R8: In a cycle where done is low, physAddr, fault and faultCause are all zero.
- R9: A configuration write changes the entry for requests sampled from the next clock edge on. A request sampled at the same edge as the write sees the entry's previous contents.
- R10: reqKind encodes 00 read, 01 write, 10 fetch. The spare code 11 is checked as a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write one table entry this cycle |
| cfgIdx | input | PAGE_BITS | Page index of the entry being written |
| cfgFrame | input | FRAME_BITS | Frame number for the entry |
| cfgPerm | input | 4 | Entry flags {present, read, write, execute}, bit 3 down to bit 0 |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | PAGE_BITS+OFFSET_BITS | Logical address |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| physAddr | output | FRAME_BITS+OFFSET_BITS | Translated address, zero on fault or when idle |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Access refused |
| faultCause | output | 2 | 00 none, 01 not present, 10 write denied, 11 read/fetch denied |

## Verification
The assertions assume reqValid and cfgWe stay low while rstN is low. Under that assumption every result registered after reset belongs to a request that was sampled out of reset. The bench holds both strobes low through reset and drives every input only on falling edges. The offset and cause checks therefore always see the values that were present at the sampling edge. The stimulus uses only the three defined access kinds, except for a few vectors that exercise the spare code, and those are judged as reads.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_SPARE = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_ABSENT   = 2'b01,
    CAUSE_NOWRITE  = 2'b10,
    CAUSE_NOACCESS = 2'b11
  } cause_e;

  // entry flags, bit order matches the cfgPerm port
  typedef struct packed {
    logic present;
    logic canRead;
    logic canWrite;
    logic canExec;
  } perm_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic load;
  } strobes_t;

endpackage

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     cfgWe,
  output strobes_t strb,
  output logic     done
);

  always_comb begin
    strb.capture = reqValid;
    strb.load    = cfgWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= reqValid;
  end

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done); // R2

  AST_NO_DONE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done); // R2

endmodule

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int PAGE_BITS   = 3,
  parameter int OFFSET_BITS = 12,
  parameter int FRAME_BITS  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobes_t                        strb,
  input  logic [PAGE_BITS-1:0]            cfgIdx,
  input  logic [FRAME_BITS-1:0]           cfgFrame,
  input  perm_t                           cfgPerm,
  input  logic [PAGE_BITS+OFFSET_BITS-1:0] reqAddr,
  input  logic [1:0]                      reqKind,
  output logic [FRAME_BITS+OFFSET_BITS-1:0] physAddr,
  output logic                            fault,
  output logic [1:0]                      faultCause
);

  localparam int ENTRIES = 2 ** PAGE_BITS;
  localparam int LA_W    = PAGE_BITS + OFFSET_BITS;
  localparam int PA_W    = FRAME_BITS + OFFSET_BITS;

  perm_t                 permTbl  [ENTRIES];
  logic [FRAME_BITS-1:0] frameTbl [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        permTbl[e]  <= '0;
        frameTbl[e] <= '0;
      end else if (strb.load && cfgIdx == PAGE_BITS'(e)) begin
        permTbl[e]  <= cfgPerm;
        frameTbl[e] <= cfgFrame;
      end
    end
  end

  logic [PAGE_BITS-1:0] pageIdx;
  perm_t                selPerm;
  cause_e               causeNext;
  logic [PA_W-1:0]      translated;

  always_comb begin
    pageIdx    = reqAddr[LA_W-1:OFFSET_BITS];
    selPerm    = permTbl[pageIdx];
    translated = {frameTbl[pageIdx], reqAddr[OFFSET_BITS-1:0]};
    if (!selPerm.present) begin
      causeNext = CAUSE_ABSENT;
    end else begin
      unique case (kind_e'(reqKind))
        KIND_WRITE: causeNext = selPerm.canWrite ? CAUSE_NONE : CAUSE_NOWRITE;
        KIND_FETCH: causeNext = selPerm.canExec  ? CAUSE_NONE : CAUSE_NOACCESS;
        default:    causeNext = selPerm.canRead  ? CAUSE_NONE : CAUSE_NOACCESS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.capture) begin
      physAddr   <= '0;
      fault      <= 1'b0;
      faultCause <= CAUSE_NONE;
    end else begin
      physAddr   <= (causeNext == CAUSE_NONE) ? translated : '0;
      fault      <= (causeNext != CAUSE_NONE);
      faultCause <= causeNext;
    end
  end

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> physAddr == '0); // R7

  AST_FLAG_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    fault == (faultCause != 2'b00)); // R7

  AST_OFFSET_PASSED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.capture) && !fault)
      |-> physAddr[OFFSET_BITS-1:0] == $past(reqAddr[OFFSET_BITS-1:0])); // R3

  AST_WRITE_NOT_READCAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.capture) && $past(reqKind) == 2'b01)
      |-> faultCause != 2'b11); // R5

endmodule

// File: rtl/page_guard.sv
module page_guard
  import pg_pkg::*;
#(
  parameter int PAGE_BITS   = 3,
  parameter int OFFSET_BITS = 12,
  parameter int FRAME_BITS  = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWe,
  input  logic [PAGE_BITS-1:0]              cfgIdx,
  input  logic [FRAME_BITS-1:0]             cfgFrame,
  input  logic [3:0]                        cfgPerm,
  input  logic                              reqValid,
  input  logic [PAGE_BITS+OFFSET_BITS-1:0]  reqAddr,
  input  logic [1:0]                        reqKind,
  output logic [FRAME_BITS+OFFSET_BITS-1:0] physAddr,
  output logic                              done,
  output logic                              fault,
  output logic [1:0]                        faultCause
);

  strobes_t strb;

  pg_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWe    (cfgWe),
    .strb     (strb),
    .done     (done)
  );

  pg_datapath #(
    .PAGE_BITS   (PAGE_BITS),
    .OFFSET_BITS (OFFSET_BITS),
    .FRAME_BITS  (FRAME_BITS)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgIdx     (cfgIdx),
    .cfgFrame   (cfgFrame),
    .cfgPerm    (perm_t'(cfgPerm)),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .physAddr   (physAddr),
    .fault      (fault),
    .faultCause (faultCause)
  );

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (physAddr == '0 && !fault && faultCause == 2'b00)); // R8

endmodule

// File: tb/sim_page_guard.sv
module sim_page_guard;

  localparam int PB = 3;
  localparam int OB = 12;
  localparam int FB = 8;
  localparam int NP = 2 ** PB;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgWe = 1'b0;
  logic [PB-1:0]   cfgIdx = '0;
  logic [FB-1:0]   cfgFrame = '0;
  logic [3:0]      cfgPerm = '0;
  logic            reqValid = 1'b0;
  logic [PB+OB-1:0] reqAddr = '0;
  logic [1:0]      reqKind = '0;
  logic [FB+OB-1:0] physAddr;
  logic            done;
  logic            fault;
  logic [1:0]      faultCause;

  int vectors = 0;
  int miscompares = 0;

  // behavioural table model
  bit mPres [NP];
  bit mRd   [NP];
  bit mWr   [NP];
  bit mEx   [NP];
  int mFrame[NP];

  always #10ns clk = ~clk;

  page_guard #(.PAGE_BITS(PB), .OFFSET_BITS(OB), .FRAME_BITS(FB)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgFrame(cfgFrame),
    .cfgPerm(cfgPerm), .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .physAddr(physAddr), .done(done), .fault(fault), .faultCause(faultCause)
  );

  task automatic compare(input int expPhys, input bit expDone, input bit expFault,
                         input int expCause, input string tag);
    vectors++;
    if (int'(physAddr) != expPhys || done != expDone || fault != expFault ||
        int'(faultCause) != expCause) begin
      miscompares++;
      $display("FAIL %s: got phys=%h done=%0d fault=%0d cause=%0d, expected phys=%h done=%0d fault=%0d cause=%0d",
               tag, physAddr, done, fault, faultCause, expPhys, expDone, expFault, expCause);
    end
  endtask

  // one cycle: drive after a falling edge, model at the rising edge, check at the next falling edge
  task automatic step(input bit rq, input int kind, input int page, input int offs,
                      input bit we, input int idx, input int frm, input int perm,
                      input string tag);
    int expCause;
    int expPhys;
    reqValid = rq;
    reqKind  = 2'(kind);
    reqAddr  = {PB'(page), OB'(offs)};
    cfgWe    = we;
    cfgIdx   = PB'(idx);
    cfgFrame = FB'(frm);
    cfgPerm  = 4'(perm);
    @(posedge clk);
    expCause = 0;
    expPhys  = 0;
    if (rq) begin
      if (!mPres[page])      expCause = 1;
      else if (kind == 1)    expCause = mWr[page] ? 0 : 2;
      else if (kind == 2)    expCause = mEx[page] ? 0 : 3;
      else                   expCause = mRd[page] ? 0 : 3;
      if (expCause == 0) expPhys = mFrame[page] * (2 ** OB) + offs;
    end
    if (we) begin
      mPres[idx]  = perm[3];
      mRd[idx]    = perm[2];
      mWr[idx]    = perm[1];
      mEx[idx]    = perm[0];
      mFrame[idx] = frm;
    end
    @(negedge clk);
    compare(expPhys, rq, expCause != 0, expCause, tag);
  endtask

  task automatic access(input int kind, input int page, input int offs, input string tag);
    step(1'b1, kind, page, offs, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic load(input int idx, input int frm, input int perm, input string tag);
    step(1'b0, 0, 0, 0, 1'b1, idx, frm, perm, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      mPres[i] = 0; mRd[i] = 0; mWr[i] = 0; mEx[i] = 0; mFrame[i] = 0;
    end
    // R1: outputs quiet during and after reset
    repeat (3) @(negedge clk);
    compare(0, 0, 0, 0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare(0, 0, 0, 0, "R1 after reset");
    // R1 R4: every page starts absent
    for (int p = 0; p < NP; p++) access(0, p, p * 100, "R1 R4 cleared table");

    // R4 example map: pages 0..5 present, 6 and 7 absent; flags {present,read,write,exec}
    load(0, 8'h10, 4'b1111, "R8 idle during load");
    load(1, 8'h21, 4'b1100, "R8 idle during load");
    load(2, 8'h32, 4'b1110, "R8 idle during load");
    load(3, 8'h43, 4'b1001, "R8 idle during load");
    load(4, 8'h54, 4'b1010, "R8 idle during load");
    load(5, 8'hFF, 4'b1000, "R8 idle during load");
    load(6, 8'h66, 4'b0111, "R8 idle during load");

    // R3 R5 R6 R4 R7: every page under every defined kind, back to back (R2)
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 3; k++)
        access(k, p, (p * 37 + k * 911) % 4096, "R3 R4 R5 R6 R7 R2 sweep");

    // R3 offset boundaries
    access(0, 0, 0,      "R3 offset zero");
    access(0, 0, 12'hFFF, "R3 offset max");
    access(2, 3, 12'hFFF, "R3 fetch max offset");
    access(1, 5, 12'h800, "R5 write on flagless page");
    access(0, 5, 12'h001, "R6 read on flagless page");

    // R10: spare kind judged as read
    access(3, 1, 12'h123, "R10 spare kind on readable page");
    access(3, 3, 12'h456, "R10 spare kind on fetch-only page");
    access(3, 4, 12'h789, "R10 spare kind on write-only page");

    // R8 R2: idle gap then isolated request
    step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R8 idle");
    step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R8 idle");
    access(1, 2, 12'hABC, "R2 isolated write");
    step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R2 done drops");

    // R9: write and request on the same edge see the old entry
    step(1'b1, 0, 6, 12'h0F0, 1'b1, 6, 8'hA6, 4'b1111, "R9 same-edge old entry");
    access(0, 6, 12'h0F0, "R9 new entry visible");
    step(1'b1, 2, 0, 12'h314, 1'b1, 0, 8'hC0, 4'b1100, "R9 remap same edge");
    access(2, 0, 12'h314, "R9 exec removed");
    access(0, 0, 12'h314, "R9 new frame");
    // R4: present bit cleared on a page with all permissions
    load(1, 8'h21, 4'b0111, "R8 idle during load");
    access(0, 1, 12'h222, "R4 absent despite permissions");
    access(1, 7, 12'h333, "R4 page 7 absent");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule